// File: doc/BRIEF.md
# Partial Bypass Operand Forwarder

This block resolves the two source operands of the instruction sitting in the register-read stage of an in-order pipeline. Only a chosen subset of producing stages is wired back to the operand inputs. The front end delivers one instruction per cycle into one of three back-end pipes: an ALU pipe (X1, X2, XWB), a load/store pipe (M1, M2, MWB) and a long-latency arithmetic pipe (D1, D2, DWB).

For each operand the block looks at the nine back-end stage slots, each given as a valid bit, a destination register and a result. It finds the youngest in-flight writer of the source register. It then takes one of three actions:
- forward that writer's result, if the stage has an enabled path and the result exists;
- pass the register-file read data through, if nothing in flight writes the register;
- stall.

Two static 7-bit masks, one per operand, say which stages own a path back to that operand.

The register-read handoff is a valid/ready pair. `cons_valid` marks a real instruction in the register-read stage, and `cons_ready` says that both of its operands can be supplied this cycle. `cons_ready` may drop whether or not `cons_valid` is high. The instruction moves into the back end only in a cycle where both are high, and `issue_valid` is then high. In a cycle with `cons_valid` high and `cons_ready` low, the front end holds and `issue_valid` low injects a bubble. The decision is combinational and is made again every cycle.

Top module: `fwd_unit`

## Requirements
- R1: A source operand whose register has no valid in-flight writer, or whose register is 0, takes the register-file read data and causes no stall.
- R2: When the youngest valid writer of a source register sits in a stage whose mask bit is set and whose result is computed, the operand equals that stage's result.
- R3: When the youngest valid writer sits in a stage whose mask bit is clear, the block stalls, even if an older writer of the same register has an enabled path. Once that writer advances to an enabled stage, the next cycle's decision forwards it.
- R4: A youngest writer in M1 or D1 always causes a stall, since its result does not exist yet, whatever the masks hold.
- R5: A stage slot whose valid bit is low never counts as a writer.
- R6: Each operand has its own mask with bit 0 = DWB, 1 = D2, 2 = MWB, 3 = M2, 4 = XWB, 5 = X2, 6 = X1. Stage slot ports are indexed 0 = DWB, 1 = D2, 2 = MWB, 3 = M2, 4 = XWB, 5 = X2, 6 = X1, 7 = M1, 8 = D1. A stall on either operand drops `cons_ready`.
- R7: `issue_valid` is high exactly when `cons_valid` and `cons_ready` are both high. `cons_valid` low never raises `issue_valid`.
- R8: Mask value 28 (0x1C) forwards from XWB, M2 and MWB only. A youngest writer in X2 then stalls.
- R9: Age order is first-stage slots (X1, M1, D1), then second-stage slots (X2, M2, D2), then writeback slots (XWB, MWB, DWB). The youngest writer wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_a | input | 7 | Forwarding-path mask for operand A |
| cfg_b | input | 7 | Forwarding-path mask for operand B |
| st_valid | input | 9 | Valid bit per back-end stage slot |
| st_dest | input | 9 x RW | Destination register per stage slot |
| st_data | input | 9 x DW | Result per stage slot |
| cons_valid | input | 1 | Register-read stage holds an instruction |
| src_a | input | RW | Source register of operand A |
| src_b | input | RW | Source register of operand B |
| rf_a | input | DW | Register-file read data for operand A |
| rf_b | input | DW | Register-file read data for operand B |
| cons_ready | output | 1 | Both operands can be supplied this cycle |
| issue_valid | output | 1 | Instruction enters the back end this cycle |
| opnd_a | output | DW | Resolved operand A |
| opnd_b | output | DW | Resolved operand B |

## Verification
The checker examines every cycle:
- the handshake, where a held instruction never issues;
- register 0 falling through to the register file;
- the idle case, with no valid slot;
- a not-yet-computed load in M1 forcing a stall;
- a disabled X1 writer forcing a stall;
- forwarding from an enabled X1.

The following cases depend on which stages hold which registers, so only the bench scenarios can show them: youngest-wins ordering across the three age tiers, refusal to fall back to an older writer, independence of the two masks, and a stall releasing once its writer reaches an enabled stage.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  // Back-end stage slots; the first NBYP have a possible forwarding path
  localparam int NSTG = 9;
  localparam int NBYP = 7;
  localparam int S_DWB = 0;
  localparam int S_D2  = 1;
  localparam int S_MWB = 2;
  localparam int S_M2  = 3;
  localparam int S_XWB = 4;
  localparam int S_X2  = 5;
  localparam int S_X1  = 6;
  localparam int S_M1  = 7;
  localparam int S_D1  = 8;
  // Youngest first: first-stage tier, second-stage tier, writeback tier
  localparam int YOUNG_ORDER [NSTG] = '{S_X1, S_M1, S_D1,
                                        S_X2, S_M2, S_D2,
                                        S_XWB, S_MWB, S_DWB};
endpackage

// File: rtl/fwd_match.sv
module fwd_match
  import fwd_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0]            src,
  input  logic [NSTG-1:0]          st_valid,
  input  logic [NSTG-1:0][RW-1:0]  st_dest,
  output logic [NSTG-1:0]          hit
);
  logic src_live;
  assign src_live = (src != '0);

  for (genvar s = 0; s < NSTG; s++) begin : g_cmp
    assign hit[s] = src_live && st_valid[s] && (st_dest[s] == src);
  end
endmodule

// File: rtl/fwd_pick.sv
module fwd_pick
  import fwd_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [NSTG-1:0]          hit,
  input  logic [NBYP-1:0]          mask,
  input  logic [NSTG-1:0][DW-1:0]  st_data,
  input  logic [DW-1:0]            rf_data,
  output logic [DW-1:0]            opnd,
  output logic                     stall
);
  localparam int NLATE = NSTG - NBYP;

  // Slots past NBYP never hold a finished result
  logic [NSTG-1:0] fwd_ok;
  assign fwd_ok = {{NLATE{1'b0}}, mask};

  logic found;
  always_comb begin
    found = 1'b0;
    stall = 1'b0;
    opnd  = rf_data;
    for (int k = 0; k < NSTG; k++) begin
      if (!found && hit[YOUNG_ORDER[k]]) begin
        found = 1'b1;
        if (fwd_ok[YOUNG_ORDER[k]]) opnd  = st_data[YOUNG_ORDER[k]];
        else                        stall = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic [NBYP-1:0]          cfg_a,
  input  logic [NBYP-1:0]          cfg_b,
  input  logic [NSTG-1:0]          st_valid,
  input  logic [NSTG-1:0][RW-1:0]  st_dest,
  input  logic [NSTG-1:0][DW-1:0]  st_data,
  input  logic                     cons_valid,
  input  logic [RW-1:0]            src_a,
  input  logic [RW-1:0]            src_b,
  input  logic [DW-1:0]            rf_a,
  input  logic [DW-1:0]            rf_b,
  output logic                     cons_ready,
  output logic                     issue_valid,
  output logic [DW-1:0]            opnd_a,
  output logic [DW-1:0]            opnd_b
);
  localparam int NOPS = 2;

  logic [NOPS-1:0][RW-1:0]   srcs;
  logic [NOPS-1:0][NBYP-1:0] masks;
  logic [NOPS-1:0][DW-1:0]   rfs;
  logic [NOPS-1:0][DW-1:0]   outs;
  logic [NOPS-1:0][NSTG-1:0] hits;
  logic [NOPS-1:0]           stalls;

  assign srcs  = {src_b, src_a};
  assign masks = {cfg_b, cfg_a};
  assign rfs   = {rf_b, rf_a};

  for (genvar o = 0; o < NOPS; o++) begin : g_op
    fwd_match #(.RW(RW)) u_match (
      .src      (srcs[o]),
      .st_valid (st_valid),
      .st_dest  (st_dest),
      .hit      (hits[o])
    );
    fwd_pick #(.DW(DW)) u_pick (
      .hit     (hits[o]),
      .mask    (masks[o]),
      .st_data (st_data),
      .rf_data (rfs[o]),
      .opnd    (outs[o]),
      .stall   (stalls[o])
    );
  end

  assign opnd_a      = outs[0];
  assign opnd_b      = outs[1];
  assign cons_ready  = ~|stalls;
  assign issue_valid = cons_valid & cons_ready;
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk
  import fwd_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 5
) (
  input logic [NBYP-1:0]          cfg_a,
  input logic [NBYP-1:0]          cfg_b,
  input logic [NSTG-1:0]          st_valid,
  input logic [NSTG-1:0][RW-1:0]  st_dest,
  input logic [NSTG-1:0][DW-1:0]  st_data,
  input logic                     cons_valid,
  input logic [RW-1:0]            src_a,
  input logic [RW-1:0]            src_b,
  input logic [DW-1:0]            rf_a,
  input logic [DW-1:0]            rf_b,
  input logic                     cons_ready,
  input logic                     issue_valid,
  input logic [DW-1:0]            opnd_a,
  input logic [DW-1:0]            opnd_b
);
  logic x1_hits_a, m1_hits_a;
  assign x1_hits_a = st_valid[S_X1] && (st_dest[S_X1] == src_a) && (src_a != '0);
  assign m1_hits_a = st_valid[S_M1] && (st_dest[S_M1] == src_a) && (src_a != '0);

  always_comb begin
    // R7
    if (cons_valid && !cons_ready)
      bubble_on_hold_chk: assert (!issue_valid) else $error("held instruction issued");
    // R7
    if (!cons_valid)
      no_phantom_issue_chk: assert (!issue_valid) else $error("issue without instruction");
    // R1
    if (src_a == '0)
      zero_reg_rf_chk: assert (opnd_a == rf_a) else $error("register 0 not from file");
    // R5
    if (st_valid == '0)
      idle_pass_chk: assert (cons_ready && opnd_a == rf_a && opnd_b == rf_b)
        else $error("idle pipe altered operands");
    // R4
    if (m1_hits_a && !st_valid[S_X1])
      unready_load_chk: assert (!cons_ready) else $error("M1 result forwarded");
    // R3
    if (x1_hits_a && !cfg_a[S_X1])
      disabled_path_chk: assert (!cons_ready) else $error("disabled X1 path used");
    // R2
    if (x1_hits_a && cfg_a[S_X1] && src_b == '0)
      x1_forward_chk: assert (cons_ready && opnd_a == st_data[S_X1])
        else $error("X1 forward missed");
  end
endmodule

bind fwd_unit fwd_unit_chk #(.DW(DW), .RW(RW)) u_chk (
  .cfg_a       (cfg_a),
  .cfg_b       (cfg_b),
  .st_valid    (st_valid),
  .st_dest     (st_dest),
  .st_data     (st_data),
  .cons_valid  (cons_valid),
  .src_a       (src_a),
  .src_b       (src_b),
  .rf_a        (rf_a),
  .rf_b        (rf_b),
  .cons_ready  (cons_ready),
  .issue_valid (issue_valid),
  .opnd_a      (opnd_a),
  .opnd_b      (opnd_b)
);

// File: tb/fwd_unit_test.sv
module fwd_unit_test;
  localparam int DW = 32;
  localparam int RW = 5;
  localparam int NS = 9;
  localparam logic [31:0] RFA = 32'h0000_AAAA;
  localparam logic [31:0] RFB = 32'h0000_BBBB;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [6:0]             cfg_a, cfg_b;
  logic [NS-1:0]          st_valid;
  logic [NS-1:0][RW-1:0]  st_dest;
  logic [NS-1:0][DW-1:0]  st_data;
  logic                   cons_valid;
  logic [RW-1:0]          src_a, src_b;
  logic [DW-1:0]          rf_a, rf_b;
  logic                   cons_ready, issue_valid;
  logic [DW-1:0]          opnd_a, opnd_b;

  fwd_unit #(.DW(DW), .RW(RW)) uut (
    .cfg_a(cfg_a), .cfg_b(cfg_b), .st_valid(st_valid), .st_dest(st_dest),
    .st_data(st_data), .cons_valid(cons_valid), .src_a(src_a), .src_b(src_b),
    .rf_a(rf_a), .rf_b(rf_b), .cons_ready(cons_ready),
    .issue_valid(issue_valid), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  // Slot bits: 0 DWB,1 D2,2 MWB,3 M2,4 XWB,5 X2,6 X1,7 M1,8 D1
  // ha slots write src a, hb slots write src b, other valid slots write r20+i
  typedef struct packed {
    logic [6:0] cfa;
    logic [6:0] cfb;
    logic [8:0] vld;
    logic [8:0] ha;
    logic [8:0] hb;
    logic [4:0] sa;
    logic [4:0] sb;
    logic       rdy;
    logic [3:0] ea;   // expected source slot, F = register file
    logic [3:0] eb;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{7'h00, 7'h00, 9'h1FF, 9'h000, 9'h000, 5'd5, 5'd6, 1'b1, 4'hF, 4'hF}, // R1 nothing matches
    '{7'h7F, 7'h7F, 9'h040, 9'h040, 9'h000, 5'd5, 5'd6, 1'b1, 4'h6, 4'hF}, // R2 from X1
    '{7'h7F, 7'h7F, 9'h030, 9'h030, 9'h000, 5'd5, 5'd6, 1'b1, 4'h5, 4'hF}, // R9 X2 beats XWB
    '{7'h1C, 7'h7F, 9'h010, 9'h010, 9'h000, 5'd5, 5'd6, 1'b1, 4'h4, 4'hF}, // R8 XWB enabled
    '{7'h1C, 7'h7F, 9'h020, 9'h020, 9'h000, 5'd5, 5'd6, 1'b0, 4'hF, 4'hF}, // R8 X2 disabled
    '{7'h1C, 7'h7F, 9'h030, 9'h030, 9'h000, 5'd5, 5'd6, 1'b0, 4'hF, 4'hF}, // R3 no fallback to XWB
    '{7'h7F, 7'h7F, 9'h080, 9'h080, 9'h000, 5'd5, 5'd6, 1'b0, 4'hF, 4'hF}, // R4 load in M1
    '{7'h7F, 7'h7F, 9'h101, 9'h101, 9'h000, 5'd5, 5'd6, 1'b0, 4'hF, 4'hF}, // R4 D1 over DWB
    '{7'h7F, 7'h7F, 9'h000, 9'h040, 9'h000, 5'd5, 5'd6, 1'b1, 4'hF, 4'hF}, // R5 invalid X1
    '{7'h7F, 7'h7F, 9'h040, 9'h040, 9'h000, 5'd0, 5'd6, 1'b1, 4'hF, 4'hF}, // R1 register 0
    '{7'h22, 7'h04, 9'h024, 9'h020, 9'h004, 5'd5, 5'd6, 1'b1, 4'h5, 4'h2}, // R6 split masks
    '{7'h22, 7'h22, 9'h024, 9'h020, 9'h004, 5'd5, 5'd6, 1'b0, 4'hF, 4'hF}, // R6 b stalls
    '{7'h7F, 7'h7F, 9'h108, 9'h008, 9'h100, 5'd5, 5'd6, 1'b0, 4'hF, 4'hF}, // R4 b in D1
    '{7'h7F, 7'h7F, 9'h009, 9'h008, 9'h001, 5'd5, 5'd6, 1'b1, 4'h3, 4'h0}, // R2 M2 and DWB
    '{7'h7F, 7'h7F, 9'h046, 9'h002, 9'h004, 5'd5, 5'd6, 1'b1, 4'h1, 4'h2}, // R2 D2 and MWB
    '{7'h20, 7'h00, 9'h020, 9'h020, 9'h000, 5'd5, 5'd5, 1'b0, 4'hF, 4'hF}  // R6 same reg, b masked
  };

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] expv(input logic [3:0] sel, input logic [31:0] rf);
    return (sel == 4'hF) ? rf : (32'hC0DE_0000 | 32'(sel));
  endfunction

  task automatic drive(input vec_t v);
    cfg_a = v.cfa;
    cfg_b = v.cfb;
    src_a = v.sa;
    src_b = v.sb;
    for (int i = 0; i < NS; i++) begin
      st_valid[i] = v.vld[i];
      st_dest[i]  = v.ha[i] ? v.sa : (v.hb[i] ? v.sb : 5'(20 + i));
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NS; i++) st_data[i] = 32'hC0DE_0000 | 32'(i);
    rf_a = RFA; rf_b = RFB;
    cons_valid = 1'b1;
    cfg_a = '0; cfg_b = '0; src_a = 5'd5; src_b = 5'd6;
    st_valid = '0; st_dest = '0;

    // Start-up state: empty back end (R5, R1)
    @(negedge clk); #2;
    chk("R5 idle ready", 32'(cons_ready), 32'd1);
    chk("R1 idle opnd_a", opnd_a, RFA);
    chk("R1 idle opnd_b", opnd_b, RFB);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      drive(VECS[k]);
      #2;
      chk($sformatf("vec %0d ready", k), 32'(cons_ready), 32'(VECS[k].rdy));
      chk($sformatf("R7 vec %0d issue", k), 32'(issue_valid), 32'(VECS[k].rdy));
      if (VECS[k].rdy) begin
        chk($sformatf("vec %0d opnd_a", k), opnd_a, expv(VECS[k].ea, RFA));
        chk($sformatf("vec %0d opnd_b", k), opnd_b, expv(VECS[k].eb, RFB));
      end
    end

    // R7: no instruction, stalled operands -> no issue
    @(negedge clk);
    drive(VECS[4]);
    cons_valid = 1'b0;
    #2;
    chk("R7 idle stall ready", 32'(cons_ready), 32'd0);
    chk("R7 idle stall issue", 32'(issue_valid), 32'd0);
    @(negedge clk);
    drive(VECS[0]);
    #2;
    chk("R7 idle free ready", 32'(cons_ready), 32'd1);
    chk("R7 idle free issue", 32'(issue_valid), 32'd0);
    cons_valid = 1'b1;

    // R3 stall then release as the writer walks X2 -> XWB -> retired (mask 0x1C)
    @(negedge clk);
    drive(VECS[4]);
    #2;
    chk("R3 hold in X2", 32'(cons_ready), 32'd0);
    @(negedge clk);
    drive(VECS[3]);
    #2;
    chk("R3 release ready", 32'(cons_ready), 32'd1);
    chk("R3 release value", opnd_a, 32'hC0DE_0004);
    @(negedge clk);
    st_valid = '0;
    #2;
    chk("R1 after retire", opnd_a, RFA);

    // R3: X1 newest disabled, XWB older enabled -> stall
    @(negedge clk);
    cfg_a = 7'h10;
    st_valid = '0;
    st_valid[6] = 1'b1; st_dest[6] = 5'd5;
    st_valid[4] = 1'b1; st_dest[4] = 5'd5;
    #2;
    chk("R3 stale writer refused", 32'(cons_ready), 32'd0);
    chk("R7 stale issue", 32'(issue_valid), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule